// File: doc/BRIEF.md
# Wide Mantissa Align-Add-Normalize Unit

This block is the back half of a fused multiply-add datapath. It takes an unrounded double-width product mantissa, whose leading one sits at bit 126 or bit 127 of a 128-bit word, together with its exponent and sign. It also takes a 53-bit addend mantissa with its exponent and sign. It returns one sum with no rounding at any intermediate step. The result is a 56-bit mantissa (53 significant bits plus guard, round and sticky) with its sign and unbiased exponent, ready for a separate rounding and packing stage.

The addend is lifted into the 128-bit frame so that its leading one lines up with the product's. The operand with the smaller exponent is shifted right with sticky collection. The two are added or subtracted at full width, and the result is renormalized so that its leading one returns to bit 126. The final sticky right shift places that one at bit 55. An exact cancellation is flagged as a zero result whose sign depends on the rounding direction. An addend marked zero bypasses the sum, and only the product is narrowed. Exponents are signed two's-complement values, and the result is registered one cycle after a valid input.

Top module: `fma_align_add_norm`

## Requirements
- R1: When bit 127 of the product mantissa is set, the product is sticky-shifted right by one and its exponent is raised by one before any other step.
- R2: The operand with the smaller exponent is sticky-shifted right by the exponent difference, and the result exponent starts from the larger exponent. A difference of 128 or more reduces that operand to a lone sticky bit.
- R3: With equal signs the operands are added. A carry into bit 127 causes a sticky right shift by one and an exponent increment.
- R4: With different signs the smaller magnitude is taken from the larger. The result sign is that of the larger operand.
- R5: An exact zero difference sets res_zero=1, res_man=0 and res_exp=0. res_sign is 1 when round_down=1 and 0 otherwise.
- R6: After a subtraction the value is shifted left until bit 126 is set, and the exponent is lowered by the shift count.
- R7: res_man is the 128-bit result shifted right by 71. Bit 0 of res_man is ORed with every discarded bit, so a nonzero result has res_man[55]=1.
- R8: When add_zero=1 the addend is ignored. The result is the product alone after the R1 step, narrowed as in R7, with the product's sign and exponent and res_zero=0.
- R9: out_valid is 0 in reset and equals in_valid of the previous cycle. Result fields load only when in_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| prod_man | input | 128 | Product mantissa, leading one at bit 126 or 127 |
| prod_exp | input | EW | Product exponent, signed |
| prod_sign | input | 1 | Product sign (1 = negative) |
| add_man | input | MW | Addend mantissa, leading one at bit MW-1 |
| add_exp | input | EW | Addend exponent, signed |
| add_sign | input | 1 | Addend sign |
| add_zero | input | 1 | Addend is zero |
| round_down | input | 1 | Rounding toward minus infinity is in effect |
| out_valid | output | 1 | Result valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | EW | Result exponent, signed |
| res_man | output | MW+3 | Result mantissa with guard, round and sticky |
| res_zero | output | 1 | Exact zero result |

## Verification
The hardest situation to reach from the ports is deep cancellation. Here the subtraction wipes out most of the high word, and the normalizer must find a leading one far below bit 126. The stimulus builds it by giving the addend a lowest mantissa bit that lands at bit 74, then subtracting a product equal to the addend's top bit. The exact left shift of 52 and the exponent of -52 are then known in advance. Sticky collapse is reached in a similar way, by picking exponent gaps larger than the 128-bit frame.

// File: rtl/fma_align_add_norm.sv
module fma_align_add_norm #(
  parameter int EW = 13,
  parameter int MW = 53,
  parameter int GW = 3,
  parameter int PW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] prod_man,
  input  logic [EW-1:0] prod_exp,
  input  logic          prod_sign,
  input  logic [MW-1:0] add_man,
  input  logic [EW-1:0] add_exp,
  input  logic          add_sign,
  input  logic          add_zero,
  input  logic          round_down,
  output logic          out_valid,
  output logic          res_sign,
  output logic [EW-1:0] res_exp,
  output logic [MW+GW-1:0] res_man,
  output logic          res_zero
);
  localparam int OUTW   = MW + GW;
  localparam int TOP    = PW - 2;
  localparam int ADD_SH = TOP - (MW - 1);
  localparam int SH_OUT = TOP - (OUTW - 1);
  localparam int SW     = $clog2(PW) + 1;

  function automatic logic [PW-1:0] shr_st(input logic [PW-1:0] v, input logic [SW-1:0] n);
    logic [PW-1:0] r;
    logic lost;
    if (n >= SW'(PW)) begin
      r = '0;
      r[0] = |v;
    end else begin
      lost = |(v & ~({PW{1'b1}} << n));
      r = v >> n;
      r[0] = r[0] | lost;
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] lzc(input logic [PW-1:0] v);
    logic [SW-1:0] c;
    logic found;
    c = '0;
    found = 1'b0;
    for (int i = TOP; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else c = c + 1'b1;
      end
    end
    return c;
  endfunction

  logic [PW-1:0] p1, pa, aa, acc, tmp;
  logic [EW-1:0] p1e, e;
  logic [EW:0]   ed, ad;
  logic [SW-1:0] amt, lz;
  logic          n_sign, n_zero;
  logic [EW-1:0] n_exp;
  logic [OUTW-1:0] n_man;

  always_comb begin
    p1  = prod_man;
    p1e = prod_exp;
    if (p1[PW-1]) begin
      p1  = shr_st(p1, SW'(1));
      p1e = p1e + 1'b1;
    end

    pa = p1;
    aa = {1'b0, add_man, {ADD_SH{1'b0}}};
    ed = {add_exp[EW-1], add_exp} - {p1e[EW-1], p1e};
    ad = ed[EW] ? -ed : ed;
    amt = (ad >= (EW+1)'(PW)) ? SW'(PW) : ad[SW-1:0];
    if (!ed[EW]) begin
      pa = shr_st(pa, amt);
      e  = add_exp;
    end else begin
      aa = shr_st(aa, amt);
      e  = p1e;
    end

    n_zero = 1'b0;
    lz     = '0;
    if (add_sign == prod_sign) begin
      n_sign = add_sign;
      acc = aa + pa;
      if (acc[PW-1]) begin
        acc = shr_st(acc, SW'(1));
        e   = e + 1'b1;
      end
    end else begin
      if (aa >= pa) begin
        acc    = aa - pa;
        n_sign = add_sign;
      end else begin
        acc    = pa - aa;
        n_sign = prod_sign;
      end
      lz  = lzc(acc);
      acc = acc << lz;
      e   = e - {{(EW-SW){1'b0}}, lz};
    end

    if (add_zero) begin
      acc    = p1;
      e      = p1e;
      n_sign = prod_sign;
    end else if (acc == '0) begin
      n_zero = 1'b1;
      n_sign = round_down;
      e      = '0;
    end

    tmp   = shr_st(acc, SW'(SH_OUT));
    n_man = n_zero ? '0 : OUTW'(tmp);
    n_exp = e;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_sign  <= 1'b0;
      res_exp   <= '0;
      res_man   <= '0;
      res_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_sign <= n_sign;
        res_exp  <= n_exp;
        res_man  <= n_man;
        res_zero <= n_zero;
      end
    end
  end
endmodule

module fma_align_add_norm_chk #(
  parameter int EW = 13,
  parameter int MW = 53,
  parameter int GW = 3,
  parameter int PW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          prod_sign,
  input logic          add_zero,
  input logic          round_down,
  input logic          out_valid,
  input logic          res_sign,
  input logic [MW+GW-1:0] res_man,
  input logic          res_zero
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_leading_one: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !res_zero) |-> res_man[MW+GW-1]);
  a_r5_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_zero) |-> (res_man == '0));
  a_r5_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !add_zero) |=> (!res_zero || res_sign == $past(round_down)));
  a_r8_product_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && add_zero) |=> (!res_zero && res_sign == $past(prod_sign)));
endmodule

bind fma_align_add_norm fma_align_add_norm_chk #(.EW(EW), .MW(MW), .GW(GW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prod_sign(prod_sign),
  .add_zero(add_zero), .round_down(round_down), .out_valid(out_valid),
  .res_sign(res_sign), .res_man(res_man), .res_zero(res_zero)
);

// File: tb/tb_fma_align_add_norm.sv
module tb_fma_align_add_norm;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 13, MW = 53, OW = 56, PW = 128;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [PW-1:0] prod_man = '0;
  logic [EW-1:0] prod_exp = '0, add_exp = '0;
  logic prod_sign = 1'b0, add_sign = 1'b0, add_zero = 1'b0, round_down = 1'b0;
  logic [MW-1:0] add_man = '0;
  logic out_valid, res_sign, res_zero;
  logic [EW-1:0] res_exp;
  logic [OW-1:0] res_man;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [EW+OW+1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fma_align_add_norm dut (.*);

  localparam logic [PW-1:0] P126 = 128'h1 << 126;
  localparam logic [MW-1:0] ONE  = 53'h1 << 52;
  localparam logic [OW-1:0] M55  = 56'h1 << 55;

  task automatic chk(input string tag, input logic [EW+OW+1:0] act, input logic [EW+OW+1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [PW-1:0] pm, input int pe, input logic ps,
                       input logic [MW-1:0] am, input int ae, input logic as_,
                       input logic az, input logic rd,
                       input logic xs, input int xe, input logic [OW-1:0] xm, input logic xz,
                       input string tag);
    @(negedge clk);
    prod_man = pm; prod_exp = EW'(pe); prod_sign = ps;
    add_man = am; add_exp = EW'(ae); add_sign = as_; add_zero = az; round_down = rd;
    in_valid = 1'b1;
    exp_q.push_back({xs, EW'(xe), xm, xz});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (out_valid) begin
        if (exp_q.size() == 0) chk("R9 unexpected out_valid", 1, 0);
        else chk(tag_q.pop_front(), {res_sign, res_exp, res_man, res_zero}, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", {58'b0, out_valid}, 0);
    rst_n = 1'b1;
    // R8 product only, leading one already at 126
    drive(P126, 5, 0, ONE, 40, 1, 1, 0, 0, 5, M55, 0, "R8 addend ignored");
    // R1 product at bit 127 with low bit lost to sticky
    drive((128'h1 << 127) | 128'h1, 3, 1, '0, 0, 0, 1, 0, 1, 4, M55 | 56'h1, 0, "R1 product carry shift");
    // R7 narrowing: bit 72 kept at bit 1, bit 70 folded into sticky
    drive(P126 | (128'h1 << 72), 0, 0, '0, 0, 0, 1, 0, 0, 0, M55 | 56'h2, 0, "R7 kept bit");
    drive(P126 | (128'h1 << 70), 0, 0, '0, 0, 0, 1, 0, 0, 0, M55 | 56'h1, 0, "R7 sticky bit");
    // R3 equal signs, carry out
    drive(P126, 0, 0, ONE, 0, 0, 0, 0, 0, 1, M55, 0, "R3 add carry");
    drive(P126, 0, 1, ONE, 0, 1, 0, 0, 1, 1, M55, 0, "R3 add carry negative");
    // R2 alignment by 2 and by a gap beyond the frame
    drive(P126, 0, 0, ONE, 2, 0, 0, 0, 0, 2, 56'hA0_0000_0000_0000, 0, "R2 shift product by 2");
    drive(P126, 0, 0, ONE, 200, 0, 0, 0, 0, 200, M55 | 56'h1, 0, "R2 product collapses to sticky");
    drive(P126, 300, 0, ONE, 0, 0, 0, 0, 0, 300, M55 | 56'h1, 0, "R2 addend collapses to sticky");
    // R4 and R6 opposite signs
    drive(P126, -1, 1, ONE, 0, 0, 0, 0, 0, -1, M55, 0, "R4 addend larger");
    drive(P126, 0, 1, ONE, -1, 0, 0, 0, 1, -1, M55, 0, "R4 product larger");
    drive(P126, 0, 1, ONE | 53'h1, 0, 0, 0, 0, 0, -52, M55, 0, "R6 deep cancellation");
    // R5 exact cancellation
    drive(P126, 0, 1, ONE, 0, 0, 0, 0, 0, 0, '0, 1, "R5 zero round nearest");
    drive(P126, 7, 0, ONE, 7, 1, 0, 1, 1, 0, '0, 1, "R5 zero round down");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 idle out_valid", {58'b0, out_valid}, 0);
    chk("R9 all results seen", {57'b0, exp_q.size() == 0}, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule